// File: doc/BRIEF.md
# Next-PC Selection Unit

This block works out the address of the next instruction for a 32-bit load/store core. Each cycle it takes the current program counter, a decoded control-flow kind and the operands that kind needs: two register values for the equality test, a 16-bit signed branch displacement, a 26-bit word-index jump field and a register-held target. It produces the next program counter, a flag that says control flow left the sequential path, and a request to write the return address for calls.

Three ways of forming the address are supported at once. PC-relative branches add a scaled, sign-extended displacement to the sequential address. Pseudo-direct jumps keep the top bits of the sequential address and put the word index, scaled to bytes, below them. Register-indirect jumps take the register value as it is. The results are registered, so every output shows up one clock after its inputs are sampled. There is no flow control: the unit accepts one decision per cycle. Fetch, delay slots and hazards are handled elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` holds 0 and `taken`, `link_we` and `link_val` are 0.
- R2: Outputs are registered. The values sampled at a rising edge show up on the outputs right after that edge.
- R3: Kind code 0 (sequential) gives `next_pc` = `cur_pc`+4 with `taken` = 0.
- R4: Kind code 1 (branch-if-equal) with `opnd_a` == `opnd_b` gives `next_pc` = `cur_pc`+4 + (sign-extended `br_off` × 4) with `taken` = 1.
- R5: Kind code 1 with unequal operands gives `cur_pc`+4 with `taken` = 0.
- R6: Kind code 2 (branch-if-unequal) is taken to the branch target when the operands differ. When they match it gives `cur_pc`+4 with `taken` = 0.
- R7: Bit 15 of `br_off` is a sign bit, so a negative displacement moves the target below `cur_pc`+4.
- R8: Kind code 3 (jump) gives `next_pc` = {bits 31:28 of `cur_pc`+4, `jmp_idx`, 2'b00} with `taken` = 1. For example, an index of 2500 in region 0 gives 10000.
- R9: The 4 region bits of a jump come from `cur_pc`+4, so a jump issued from the last word of a region lands in the following region.
- R10: Kind code 4 (jump-and-link) jumps as in R8 and also sets `link_we` = 1, `link_idx` = 31 and `link_val` = `cur_pc`+4.
- R11: Kind code 5 (register jump) gives `next_pc` = `reg_tgt` with `taken` = 1.
- R12: Kind codes 6 and 7 act as sequential. `link_we` is 1 only for kind code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cf_kind | input | 3 | Control-flow kind: 0 seq, 1 beq, 2 bne, 3 jump, 4 jump-and-link, 5 register jump |
| cur_pc | input | 32 | Current program counter |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| br_off | input | 16 | Signed word displacement for branches |
| jmp_idx | input | 26 | Word index for direct jumps |
| reg_tgt | input | 32 | Target for register jumps |
| next_pc | output | 32 | Registered next program counter |
| taken | output | 1 | Registered non-sequential flag |
| link_we | output | 1 | Registered return-address write request |
| link_idx | output | 5 | Register index for the link write (31) |
| link_val | output | 32 | Registered return address |

## Verification
The bench goes after the cases where a plausible design slips. If the branch offset is not sign-extended, a negative offset lands far above the branch instead of below it. If the region bits are taken from `cur_pc` rather than `cur_pc`+4, a jump from address 0x0FFFFFFC stays in region 0. If the equality sense is swapped, branch-if-unequal goes the wrong way in both the equal and the unequal case. Undefined kind codes are checked for a stray link write or redirect. The link value is compared with the sequential address rather than the target, so a design that mixes the two up is caught.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int CF_W = 3;

  typedef enum logic [CF_W-1:0] {
    CF_SEQ = 3'd0,
    CF_BEQ = 3'd1,
    CF_BNE = 3'd2,
    CF_JMP = 3'd3,
    CF_JAL = 3'd4,
    CF_JR  = 3'd5
  } cf_kind_e;
endpackage

// File: rtl/npc_addr.sv
// Candidate address generation: sequential, PC-relative and pseudo-direct.
module npc_addr #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic [TGT_W-1:0] idx,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  br_pc,
  output logic [XLEN-1:0]  jmp_pc
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int HI_W  = XLEN - TGT_W - 2;

  logic [XLEN-1:0] disp;

  assign seq_pc = pc + XLEN'(4);
  assign disp   = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  assign br_pc  = seq_pc + disp;

  generate
    if (HI_W > 0) begin : g_region
      assign jmp_pc = {seq_pc[XLEN-1 -: HI_W], idx, 2'b00};
    end else begin : g_flat
      assign jmp_pc = {idx[XLEN-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/npc_cmp.sv
// Operand equality test for conditional branches.
module npc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            eq
);
  assign eq = (a == b);
endmodule

// File: rtl/npc_select.sv
// Chooses the next address and side outputs from the decoded kind.
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CF_W-1:0] kind,
  input  logic            eq,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] br_pc,
  input  logic [XLEN-1:0] jmp_pc,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] nxt,
  output logic            tk,
  output logic            lwe
);
  always_comb begin
    nxt = seq_pc;
    tk  = 1'b0;
    lwe = 1'b0;
    case (kind)
      CF_BEQ: if (eq)  begin nxt = br_pc; tk = 1'b1; end
      CF_BNE: if (!eq) begin nxt = br_pc; tk = 1'b1; end
      CF_JMP: begin nxt = jmp_pc; tk = 1'b1; end
      CF_JAL: begin nxt = jmp_pc; tk = 1'b1; lwe = 1'b1; end
      CF_JR:  begin nxt = reg_tgt; tk = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int             XLEN     = 32,
  parameter int             OFF_W    = 16,
  parameter int             TGT_W    = 26,
  parameter int             RA_W     = 5,
  parameter logic [31:0]    RESET_PC = 32'h0,
  parameter int             LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CF_W-1:0]   cf_kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [TGT_W-1:0]  jmp_idx,
  input  logic [XLEN-1:0]   reg_tgt,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              link_we,
  output logic [RA_W-1:0]   link_idx,
  output logic [XLEN-1:0]   link_val
);
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, nxt;
  logic            eq, tk, lwe;

  npc_addr #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_addr (
    .pc(cur_pc), .off(br_off), .idx(jmp_idx),
    .seq_pc(seq_pc), .br_pc(br_pc), .jmp_pc(jmp_pc)
  );

  npc_cmp #(.XLEN(XLEN)) u_cmp (.a(opnd_a), .b(opnd_b), .eq(eq));

  npc_select #(.XLEN(XLEN)) u_sel (
    .kind(cf_kind), .eq(eq), .seq_pc(seq_pc), .br_pc(br_pc),
    .jmp_pc(jmp_pc), .reg_tgt(reg_tgt), .nxt(nxt), .tk(tk), .lwe(lwe)
  );

  assign link_idx = RA_W'(LINK_REG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc  <= XLEN'(RESET_PC);
      taken    <= 1'b0;
      link_we  <= 1'b0;
      link_val <= '0;
    end else begin
      next_pc  <= nxt;
      taken    <= tk;
      link_we  <= lwe;
      link_val <= lwe ? seq_pc : '0;
    end
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int TGT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cf_kind,
  input logic [XLEN-1:0]  cur_pc,
  input logic [XLEN-1:0]  opnd_a,
  input logic [XLEN-1:0]  opnd_b,
  input logic [XLEN-1:0]  reg_tgt,
  input logic [XLEN-1:0]  next_pc,
  input logic             taken,
  input logic             link_we,
  input logic [XLEN-1:0]  link_val
);
  // R3
  seq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cf_kind) == 3'd0) |-> (next_pc == $past(cur_pc) + XLEN'(4) && !taken));

  // R6
  bne_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cf_kind) == 3'd2 && $past(opnd_a) == $past(opnd_b))
      |-> (next_pc == $past(cur_pc) + XLEN'(4) && !taken));

  // R11
  reg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cf_kind) == 3'd5) |-> (next_pc == $past(reg_tgt) && taken));

  // R10
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && link_we) |-> (link_val == $past(cur_pc) + XLEN'(4) && taken));

  // R12
  link_only_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && link_we) |-> ($past(cf_kind) == 3'd4));

  // R8
  jump_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cf_kind) == 3'd3) |-> (taken && next_pc[1:0] == 2'b00));
endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cf_kind(cf_kind), .cur_pc(cur_pc),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .reg_tgt(reg_tgt),
  .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_val(link_val)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cf_kind = '0;
  logic [31:0] cur_pc = '0, opnd_a = '0, opnd_b = '0, reg_tgt = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we;
  logic [4:0]  link_idx;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst_n(rst_n), .cf_kind(cf_kind), .cur_pc(cur_pc),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .br_off(br_off), .jmp_idx(jmp_idx),
    .reg_tgt(reg_tgt), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, capture at the rising edge, sample 2 ns later.
  task automatic step(input logic [2:0] k, input logic [31:0] pc, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] off,
                      input logic [25:0] idx, input logic [31:0] rt);
    @(negedge clk);
    cf_kind = k; cur_pc = pc; opnd_a = a; opnd_b = b;
    br_off = off; jmp_idx = idx; reg_tgt = rt;
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    chk("R1 next_pc", next_pc, 32'h0);
    chk("R1 taken", {31'b0, taken}, 32'h0);
    chk("R1 link_we", {31'b0, link_we}, 32'h0);
    chk("R1 link_val", link_val, 32'h0);
  endtask

  task automatic t_seq();
    step(3'd0, 32'h0040_0000, 0, 0, 16'h0, 26'h0, 32'h0);
    chk("R3 R2 next_pc", next_pc, 32'h0040_0004);
    chk("R3 taken", {31'b0, taken}, 32'h0);
  endtask

  task automatic t_beq();
    step(3'd1, 32'h0040_0010, 32'd7, 32'd7, 16'd3, 26'h0, 32'h0);
    chk("R4 next_pc", next_pc, 32'h0040_0020);
    chk("R4 taken", {31'b0, taken}, 32'h1);
    step(3'd1, 32'h0040_0010, 32'd7, 32'd8, 16'd3, 26'h0, 32'h0);
    chk("R5 next_pc", next_pc, 32'h0040_0014);
    chk("R5 taken", {31'b0, taken}, 32'h0);
  endtask

  task automatic t_bne();
    step(3'd2, 32'h0040_0010, 32'd1, 32'd2, 16'd5, 26'h0, 32'h0);
    chk("R6 differ next_pc", next_pc, 32'h0040_0028);
    chk("R6 differ taken", {31'b0, taken}, 32'h1);
    step(3'd2, 32'h0040_0010, 32'd9, 32'd9, 16'd5, 26'h0, 32'h0);
    chk("R6 equal next_pc", next_pc, 32'h0040_0014);
    chk("R6 equal taken", {31'b0, taken}, 32'h0);
  endtask

  task automatic t_negative();
    step(3'd1, 32'h0040_0100, 32'd0, 32'd0, 16'hFFFE, 26'h0, 32'h0);
    chk("R7 next_pc", next_pc, 32'h0040_00FC);
  endtask

  task automatic t_jump();
    step(3'd3, 32'h0040_0000, 0, 0, 16'h0, 26'd2500, 32'h0);
    chk("R8 next_pc", next_pc, 32'd10000);
    chk("R8 taken", {31'b0, taken}, 32'h1);
    chk("R12 jump link_we", {31'b0, link_we}, 32'h0);
    step(3'd3, 32'h0FFF_FFFC, 0, 0, 16'h0, 26'h10, 32'h0);
    chk("R9 next_pc", next_pc, 32'h1000_0040);
  endtask

  task automatic t_call();
    step(3'd4, 32'h2000_1000, 0, 0, 16'h0, 26'h100, 32'h0);
    chk("R10 next_pc", next_pc, 32'h2000_0400);
    chk("R10 link_we", {31'b0, link_we}, 32'h1);
    chk("R10 link_idx", {27'b0, link_idx}, 32'd31);
    chk("R10 link_val", link_val, 32'h2000_1004);
  endtask

  task automatic t_regjump();
    step(3'd5, 32'h0040_0000, 0, 0, 16'h0, 26'h0, 32'h0040_0ABC);
    chk("R11 next_pc", next_pc, 32'h0040_0ABC);
    chk("R11 taken", {31'b0, taken}, 32'h1);
    chk("R12 jr link_we", {31'b0, link_we}, 32'h0);
  endtask

  task automatic t_undefined();
    step(3'd6, 32'h0000_0100, 32'd1, 32'd1, 16'd4, 26'h3F, 32'hDEAD_0000);
    chk("R12 code6 next_pc", next_pc, 32'h0000_0104);
    chk("R12 code6 link_we", {31'b0, link_we}, 32'h0);
    step(3'd7, 32'h0000_0200, 32'd1, 32'd2, 16'd4, 26'h3F, 32'hDEAD_0000);
    chk("R12 code7 next_pc", next_pc, 32'h0000_0204);
    chk("R12 code7 taken", {31'b0, taken}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_seq();
    t_beq();
    t_bne();
    t_negative();
    t_jump();
    t_call();
    t_regjump();
    t_undefined();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule